// File: doc/BRIEF.md
# Dual-Direction Mailbox Register Bank

This block carries 32-bit messages between a local bus and a host side through two sets of four mailboxes. The host writes the inbound set and the local side may only read it. The local side writes and reads the outbound set and the host reads it. Local accesses carry a byte address, four byte enables and separate read and write strobes. Local read data comes back one cycle after the read strobe.

Every mailbox byte has a full flag. The writing side sets it, and a read of that byte from the other side clears it. Two sticky interrupt flags drive a host interrupt request. One flag fires when a local write reaches a configured outbound mailbox byte. The other fires when a local read reaches a configured inbound mailbox byte. A configuration strap can remove the top byte of the last outbound mailbox.

A small access state machine runs the local read path. It has two states: `ST_IDLE` (no read data pending) and `ST_RESP` (registered read data valid). Its transitions are:
- `IDLE->RESP` on a read strobe
- `RESP->RESP` on back-to-back reads
- `RESP->IDLE` when the strobe drops

Top module: `mbox_bank`

## Requirements
- R1: A local read strobe sampled at a clock edge makes `loc_rvalid` high and `loc_rdata` valid after that edge. `loc_rvalid` is low after any edge at which `loc_rd` was low, and `loc_rdata` is then zero.
- R2: Inbound mailboxes m=0..3 decode where `loc_addr[5]`=0, `loc_addr[4]`=0 and `loc_addr[3:2]`=m (offsets 00h, 04h, 08h, 0Ch). A local read returns the host-written bytes in the enabled lanes (lane i = bits 8i+7:8i, enabled by `loc_be[i]`) and zero in the other lanes.
- R3: A local write to an inbound mailbox address changes neither its contents nor its full flags.
- R4: Outbound mailboxes m=0..3 decode where `loc_addr[5]`=0, `loc_addr[4]`=1 and `loc_addr[3:2]`=m (offsets 10h to 1Ch). A local write updates only the enabled byte lanes. The result is visible on the next local read and on `host_out_rdata` (combinational, selected by `host_out_sel`) after the write edge.
- R5: With `cfg_irq_wr_en`=1, a local write to outbound mailbox `cfg_irq_wr_mbox` with lane `cfg_irq_wr_byte` enabled (and existing) sets `irq_flags[0]`. No other write sets it.
- R6: With `cfg_irq_rd_en`=1, a local read of inbound mailbox `cfg_irq_rd_mbox` with lane `cfg_irq_rd_byte` enabled sets `irq_flags[1]`. Reads of outbound mailboxes never set it.
- R7: Addresses with `loc_addr[5]`=1 are undecoded. Reads return zero and writes change no mailbox.
- R8: While `cfg_bytewide_mem`=1, byte 3 of outbound mailbox 3 does not exist. Writes to it are dropped, it reads as zero on both sides, its full flag is 0, and it raises no interrupt.
- R9: `full_status[4m+b]` is the full flag of inbound mailbox m byte b, and `full_status[16+4m+b]` is the full flag of outbound mailbox m byte b. A write sets the flag. A read of that byte from the opposite side (local read for inbound, host read for outbound) clears it. When a set and a clear land in the same cycle, the set wins.
- R10: Interrupt flags are sticky until the host writes 1 to the matching `host_irq_clr` bit. A set in the same cycle wins over the clear. `host_irq` is the OR of both flags.
- R11: If `loc_wr` and `loc_rd` are both high, the cycle is a read only, and the write is ignored.
- R12: After reset, `full_status`, `irq_flags` and `loc_rvalid` are zero. Mailbox contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_addr | input | 6 | Local byte address |
| loc_be | input | 4 | Local byte enables |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Registered local read data |
| loc_rvalid | output | 1 | Read data valid |
| host_in_we | input | 1 | Host write to an inbound mailbox |
| host_in_sel | input | 2 | Inbound mailbox selected for the host write |
| host_in_be | input | 4 | Host write byte enables |
| host_in_wdata | input | 32 | Host write data |
| host_out_rd | input | 1 | Host read strobe of an outbound mailbox (clears full flags) |
| host_out_sel | input | 2 | Outbound mailbox selected for the host |
| host_out_be | input | 4 | Host read byte enables |
| host_out_rdata | output | 32 | Selected outbound mailbox contents |
| cfg_bytewide_mem | input | 1 | Strap that removes byte 3 of outbound mailbox 3 |
| cfg_irq_wr_en | input | 1 | Enable for the write interrupt |
| cfg_irq_wr_mbox | input | 2 | Outbound mailbox watched for the write interrupt |
| cfg_irq_wr_byte | input | 2 | Lane watched for the write interrupt |
| cfg_irq_rd_en | input | 1 | Enable for the read interrupt |
| cfg_irq_rd_mbox | input | 2 | Inbound mailbox watched for the read interrupt |
| cfg_irq_rd_byte | input | 2 | Lane watched for the read interrupt |
| host_irq_clr | input | 2 | Write-1-to-clear for the interrupt flags |
| irq_flags | output | 2 | Sticky flags: [0] write event, [1] read event |
| host_irq | output | 1 | Host interrupt request |
| full_status | output | 32 | Per-byte full flags |

## Verification
Local read data and `loc_rvalid` are due one edge after the read strobe. Mailbox contents, full flags and interrupt flags change at the edge that samples the access. `host_out_rdata` follows the stored contents combinationally. The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It then samples all results on the next falling edge, so each check sees the state after exactly one register stage. The check that `loc_rvalid` drops waits one further rising edge with the strobe low.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_t;

    function automatic logic [31:0] lane_mask4(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int N_MBOX = 4,
    parameter int BYTES  = 4,
    localparam int SW    = $clog2(N_MBOX),
    localparam int DW    = 8 * BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SW-1:0]           wr_sel,
    input  logic [BYTES-1:0]        wr_be,
    input  logic [DW-1:0]           wr_data,
    input  logic                    clr_en,
    input  logic [SW-1:0]           clr_sel,
    input  logic [BYTES-1:0]        clr_be,
    input  logic [N_MBOX*BYTES-1:0] absent,
    output logic [N_MBOX*DW-1:0]    data_flat,
    output logic [N_MBOX*BYTES-1:0] full_flat
);
    for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            logic [7:0] byte_q;
            logic       full_q;
            logic       wr_hit;
            logic       clr_hit;

            assign wr_hit  = wr_en && (wr_sel == SW'(m)) && wr_be[b] && !absent[m*BYTES+b];
            assign clr_hit = clr_en && (clr_sel == SW'(m)) && clr_be[b];

            always_ff @(posedge clk) begin
                if (wr_hit) byte_q <= wr_data[8*b +: 8];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  full_q <= 1'b0;
                else if (absent[m*BYTES+b])  full_q <= 1'b0;
                else if (wr_hit)             full_q <= 1'b1;
                else if (clr_hit)            full_q <= 1'b0;
            end

            assign data_flat[m*DW + 8*b +: 8] = absent[m*BYTES+b] ? 8'h00 : byte_q;
            assign full_flat[m*BYTES+b]       = full_q;
        end
    end
endmodule

// File: rtl/mbox_irq_latch.sv
module mbox_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
    parameter int N_MBOX = 4,
    parameter int BYTES  = 4,
    localparam int SW    = $clog2(N_MBOX),
    localparam int LW    = $clog2(BYTES),
    localparam int DW    = 8 * BYTES,
    localparam int AW    = SW + 4,
    localparam int NB    = N_MBOX * BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   loc_addr,
    input  logic [BYTES-1:0] loc_be,
    input  logic            loc_wr,
    input  logic            loc_rd,
    input  logic [DW-1:0]   loc_wdata,
    output logic [DW-1:0]   loc_rdata,
    output logic            loc_rvalid,
    input  logic            host_in_we,
    input  logic [SW-1:0]   host_in_sel,
    input  logic [BYTES-1:0] host_in_be,
    input  logic [DW-1:0]   host_in_wdata,
    input  logic            host_out_rd,
    input  logic [SW-1:0]   host_out_sel,
    input  logic [BYTES-1:0] host_out_be,
    output logic [DW-1:0]   host_out_rdata,
    input  logic            cfg_bytewide_mem,
    input  logic            cfg_irq_wr_en,
    input  logic [SW-1:0]   cfg_irq_wr_mbox,
    input  logic [LW-1:0]   cfg_irq_wr_byte,
    input  logic            cfg_irq_rd_en,
    input  logic [SW-1:0]   cfg_irq_rd_mbox,
    input  logic [LW-1:0]   cfg_irq_rd_byte,
    input  logic [1:0]      host_irq_clr,
    output logic [1:0]      irq_flags,
    output logic            host_irq,
    output logic [2*NB-1:0] full_status
);
    import mbox_pkg::*;

    // Local address decode
    logic          decoded;
    logic          is_out;
    logic [SW-1:0] mb;
    logic          in_rd;
    logic          out_wr;

    assign decoded = !loc_addr[AW-1];
    assign is_out  = loc_addr[AW-2];
    assign mb      = loc_addr[SW+1:2];
    assign in_rd   = loc_rd && decoded && !is_out;
    assign out_wr  = loc_wr && !loc_rd && decoded && is_out;

    // Outbound missing-byte mask from the strap
    logic [NB-1:0] out_absent;
    always_comb begin
        out_absent         = '0;
        out_absent[NB-1]   = cfg_bytewide_mem;
    end

    logic [N_MBOX*DW-1:0] in_flat,  out_flat;
    logic [NB-1:0]        in_full,  out_full;

    mbox_store #(.N_MBOX(N_MBOX), .BYTES(BYTES)) u_in_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_in_we), .wr_sel(host_in_sel), .wr_be(host_in_be), .wr_data(host_in_wdata),
        .clr_en(in_rd), .clr_sel(mb), .clr_be(loc_be),
        .absent({NB{1'b0}}),
        .data_flat(in_flat), .full_flat(in_full)
    );

    mbox_store #(.N_MBOX(N_MBOX), .BYTES(BYTES)) u_out_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(out_wr), .wr_sel(mb), .wr_be(loc_be), .wr_data(loc_wdata),
        .clr_en(host_out_rd), .clr_sel(host_out_sel), .clr_be(host_out_be),
        .absent(out_absent),
        .data_flat(out_flat), .full_flat(out_full)
    );

    // Interrupt events
    logic wr_evt, rd_evt;
    assign wr_evt = cfg_irq_wr_en && out_wr && (mb == cfg_irq_wr_mbox)
                  && loc_be[cfg_irq_wr_byte] && !out_absent[{cfg_irq_wr_mbox, cfg_irq_wr_byte}];
    assign rd_evt = cfg_irq_rd_en && in_rd && (mb == cfg_irq_rd_mbox)
                  && loc_be[cfg_irq_rd_byte];

    mbox_irq_latch u_irq_wr (.clk(clk), .rst_n(rst_n), .set(wr_evt), .clr(host_irq_clr[0]), .flag(irq_flags[0]));
    mbox_irq_latch u_irq_rd (.clk(clk), .rst_n(rst_n), .set(rd_evt), .clr(host_irq_clr[1]), .flag(irq_flags[1]));

    assign host_irq       = |irq_flags;
    assign full_status    = {out_full, in_full};
    assign host_out_rdata = out_flat[int'(host_out_sel)*DW +: DW];

    // Read data selection
    logic [DW-1:0] lane_mask;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] rdata_d;
    always_comb begin
        for (int i = 0; i < BYTES; i++) lane_mask[8*i +: 8] = {8{loc_be[i]}};
        rd_word = is_out ? out_flat[int'(mb)*DW +: DW] : in_flat[int'(mb)*DW +: DW];
        rdata_d = decoded ? (rd_word & lane_mask) : '0;
    end

    // Local access state machine
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (loc_rd)  state_d = ST_RESP;
            ST_RESP: if (!loc_rd) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_rdata <= '0;
        end else begin
            unique case (state_d)
                ST_RESP: loc_rdata <= rdata_d;
                default: loc_rdata <= '0;
            endcase
        end
    end

    assign loc_rvalid = (state_q == ST_RESP);
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
    parameter int N_MBOX = 4,
    parameter int BYTES  = 4,
    localparam int SW    = $clog2(N_MBOX),
    localparam int LW    = $clog2(BYTES),
    localparam int DW    = 8 * BYTES,
    localparam int AW    = SW + 4,
    localparam int NB    = N_MBOX * BYTES
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    loc_addr,
    input logic [BYTES-1:0] loc_be,
    input logic             loc_wr,
    input logic             loc_rd,
    input logic [DW-1:0]    loc_rdata,
    input logic             loc_rvalid,
    input logic             host_in_we,
    input logic [SW-1:0]    host_in_sel,
    input logic [BYTES-1:0] host_in_be,
    input logic [SW-1:0]    host_out_sel,
    input logic [DW-1:0]    host_out_rdata,
    input logic             cfg_bytewide_mem,
    input logic             cfg_irq_wr_en,
    input logic [SW-1:0]    cfg_irq_wr_mbox,
    input logic [LW-1:0]    cfg_irq_wr_byte,
    input logic [1:0]       host_irq_clr,
    input logic [1:0]       irq_flags,
    input logic [2*NB-1:0]  full_status
);
    a_r1_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd |=> loc_rvalid);

    a_r1_rvalid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_rd |=> (!loc_rvalid && loc_rdata == '0));

    a_r7_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && loc_addr[AW-1]) |=> loc_rdata == '0);

    a_r8_missing_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bytewide_mem && host_out_sel == SW'(N_MBOX-1)) |-> host_out_rdata[DW-1 -: 8] == 8'h00);

    a_r9_inbound_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (host_in_we && host_in_sel == '0 && host_in_be[0]) |=> full_status[0]);

    a_r5_write_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_wr_en && loc_wr && !loc_rd && !loc_addr[AW-1] && loc_addr[AW-2]
         && loc_addr[SW+1:2] == cfg_irq_wr_mbox && loc_be[cfg_irq_wr_byte]
         && !(cfg_bytewide_mem && cfg_irq_wr_mbox == SW'(N_MBOX-1) && cfg_irq_wr_byte == LW'(BYTES-1)))
        |=> irq_flags[0]);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[0] && !host_irq_clr[0]) |=> irq_flags[0]);
endmodule

bind mbox_bank mbox_bank_chk #(.N_MBOX(N_MBOX), .BYTES(BYTES)) u_mbox_bank_chk (.*);

// File: tb/test_mbox_bank.sv
module test_mbox_bank;
    import mbox_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  loc_addr = '0;
    logic [3:0]  loc_be = '0;
    logic        loc_wr = 1'b0, loc_rd = 1'b0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;
    logic        loc_rvalid;
    logic        host_in_we = 1'b0;
    logic [1:0]  host_in_sel = '0;
    logic [3:0]  host_in_be = '0;
    logic [31:0] host_in_wdata = '0;
    logic        host_out_rd = 1'b0;
    logic [1:0]  host_out_sel = '0;
    logic [3:0]  host_out_be = '0;
    logic [31:0] host_out_rdata;
    logic        cfg_bytewide_mem = 1'b0;
    logic        cfg_irq_wr_en = 1'b0;
    logic [1:0]  cfg_irq_wr_mbox = '0, cfg_irq_wr_byte = '0;
    logic        cfg_irq_rd_en = 1'b0;
    logic [1:0]  cfg_irq_rd_mbox = '0, cfg_irq_rd_byte = '0;
    logic [1:0]  host_irq_clr = '0;
    logic [1:0]  irq_flags;
    logic        host_irq;
    logic [31:0] full_status;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mbox_bank i_mbox_bank (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    function automatic logic [31:0] pat(input int m, input int k);
        return 32'h5A3C_96E1 ^ (32'h0101_0101 * (m + 1)) ^ (32'h1357_9BDF * k);
    endfunction

    task automatic loc_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        loc_addr = a; loc_be = be; loc_wdata = d; loc_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        loc_wr = 1'b0;
    endtask

    task automatic loc_read(input logic [5:0] a, input logic [3:0] be,
                            output logic [31:0] d, output logic v);
        loc_addr = a; loc_be = be; loc_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        d = loc_rdata; v = loc_rvalid;
        loc_rd = 1'b0;
    endtask

    task automatic host_write(input int m, input logic [3:0] be, input logic [31:0] d);
        host_in_sel = 2'(m); host_in_be = be; host_in_wdata = d; host_in_we = 1'b1;
        @(posedge clk); @(negedge clk);
        host_in_we = 1'b0;
    endtask

    task automatic host_read(input int m, input logic [3:0] be);
        host_out_sel = 2'(m); host_out_be = be; host_out_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        host_out_rd = 1'b0;
    endtask

    task automatic irq_clear(input logic [1:0] v);
        host_irq_clr = v;
        @(posedge clk); @(negedge clk);
        host_irq_clr = '0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        v;
        logic [31:0] exp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 full_status reset", full_status, 32'h0);
        check("R12 irq_flags reset", {30'h0, irq_flags}, 32'h0);
        check("R12 rvalid reset", {31'h0, loc_rvalid}, 32'h0);

        // Inbound mailboxes: host writes, local reads with every byte enable pattern
        for (int m = 0; m < 4; m++) begin
            host_write(m, 4'hF, pat(m, 0));
            check("R9 inbound full set", {28'h0, full_status[4*m +: 4]}, 32'hF);
            for (int be = 1; be < 16; be++) begin
                loc_read(6'(4*m), 4'(be), d, v);
                check("R2 inbound lane read", d, pat(m, 0) & lane_mask4(4'(be)));
                check("R1 rvalid after read", {31'h0, v}, 32'h1);
            end
            check("R9 inbound full cleared by local read", {28'h0, full_status[4*m +: 4]}, 32'h0);
            idle();
            check("R1 rvalid low without read", {31'h0, loc_rvalid}, 32'h0);
            check("R1 rdata zero without read", loc_rdata, 32'h0);
        end

        // R3: local write to inbound mailbox ignored
        loc_write(6'h04, 4'hF, 32'hFFFF_FFFF);
        check("R3 inbound full unchanged", {28'h0, full_status[7:4]}, 32'h0);
        loc_read(6'h04, 4'hF, d, v);
        check("R3 inbound content unchanged", d, pat(1, 0));

        // R4: outbound byte-enable merge sweep
        for (int m = 0; m < 4; m++) begin
            for (int be = 0; be < 16; be++) begin
                loc_write(6'(16 + 4*m), 4'hF, pat(m, 1));
                loc_write(6'(16 + 4*m), 4'(be), pat(m, be + 2));
                exp = (pat(m, 1) & ~lane_mask4(4'(be))) | (pat(m, be + 2) & lane_mask4(4'(be)));
                host_out_sel = 2'(m);
                #1;
                check("R4 outbound host view", host_out_rdata, exp);
                loc_read(6'(16 + 4*m), 4'hF, d, v);
                check("R4 outbound local readback", d, exp);
            end
            check("R9 outbound full set", {28'h0, full_status[16 + 4*m +: 4]}, 32'hF);
        end

        // R9: host read clears enabled outbound flags; set wins on collision
        host_read(0, 4'h5);
        check("R9 host read clears lanes", {28'h0, full_status[19:16]}, 32'hA);
        host_read(0, 4'hF);
        loc_addr = 6'h10; loc_be = 4'h1; loc_wdata = 32'h0000_00C3; loc_wr = 1'b1;
        host_out_sel = 2'd0; host_out_be = 4'hF; host_out_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        loc_wr = 1'b0; host_out_rd = 1'b0;
        check("R9 set wins over clear", {28'h0, full_status[19:16]}, 32'h1);

        // R8: strap removes byte 3 of mailbox 3
        cfg_bytewide_mem = 1'b1;
        cfg_irq_wr_en = 1'b1; cfg_irq_wr_mbox = 2'd3; cfg_irq_wr_byte = 2'd3;
        idle();
        loc_write(6'h1C, 4'hF, 32'h1122_3344);
        host_out_sel = 2'd3;
        #1;
        check("R8 host view top byte zero", host_out_rdata, 32'h0022_3344);
        check("R8 missing byte full flag", {31'h0, full_status[31]}, 32'h0);
        check("R8 no irq on missing byte", {30'h0, irq_flags}, 32'h0);
        loc_read(6'h1C, 4'hF, d, v);
        check("R8 local read top byte zero", d, 32'h0022_3344);
        cfg_bytewide_mem = 1'b0;

        // R5: write interrupt
        cfg_irq_wr_en = 1'b0; cfg_irq_wr_mbox = 2'd2; cfg_irq_wr_byte = 2'd1;
        loc_write(6'h18, 4'h2, 32'h0);
        check("R5 disabled write no irq", {30'h0, irq_flags}, 32'h0);
        cfg_irq_wr_en = 1'b1;
        loc_write(6'h18, 4'h1, 32'h0);
        check("R5 other lane no irq", {30'h0, irq_flags}, 32'h0);
        loc_write(6'h14, 4'h2, 32'h0);
        check("R5 other mailbox no irq", {30'h0, irq_flags}, 32'h0);
        loc_write(6'h18, 4'h2, 32'h0);
        check("R5 matching write sets irq", {30'h0, irq_flags}, 32'h1);
        check("R10 host_irq asserted", {31'h0, host_irq}, 32'h1);
        cfg_irq_wr_en = 1'b0;
        repeat (3) idle();
        check("R10 flag sticky", {30'h0, irq_flags}, 32'h1);
        irq_clear(2'b10);
        check("R10 wrong clear bit keeps flag", {30'h0, irq_flags}, 32'h1);
        irq_clear(2'b01);
        check("R10 clear", {30'h0, irq_flags}, 32'h0);
        check("R10 host_irq low", {31'h0, host_irq}, 32'h0);

        // R6: read interrupt
        cfg_irq_rd_en = 1'b1; cfg_irq_rd_mbox = 2'd1; cfg_irq_rd_byte = 2'd2;
        loc_read(6'h14, 4'h4, d, v);
        check("R6 outbound read no irq", {30'h0, irq_flags}, 32'h0);
        loc_read(6'h04, 4'h3, d, v);
        check("R6 other lane no irq", {30'h0, irq_flags}, 32'h0);
        loc_read(6'h04, 4'h4, d, v);
        check("R6 matching read sets irq", {30'h0, irq_flags}, 32'h2);
        check("R10 host_irq on read flag", {31'h0, host_irq}, 32'h1);
        irq_clear(2'b10);
        check("R10 read flag cleared", {30'h0, irq_flags}, 32'h0);
        cfg_irq_rd_en = 1'b0;

        // R7: undecoded addresses
        host_out_sel = 2'd0;
        #1;
        exp = host_out_rdata;
        loc_write(6'h30, 4'hF, 32'hDEAD_BEEF);
        loc_write(6'h20, 4'hF, 32'hDEAD_BEEF);
        #1;
        check("R7 undecoded write ignored", host_out_rdata, exp);
        loc_read(6'h30, 4'hF, d, v);
        check("R7 undecoded read zero", d, 32'h0);
        loc_read(6'h3C, 4'hF, d, v);
        check("R7 undecoded read zero top", d, 32'h0);

        // R11: simultaneous read and write acts as read only
        host_out_sel = 2'd1;
        #1;
        exp = host_out_rdata;
        loc_addr = 6'h14; loc_be = 4'hF; loc_wdata = ~exp; loc_wr = 1'b1; loc_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        loc_wr = 1'b0; loc_rd = 1'b0;
        check("R11 read returns old data", loc_rdata, exp);
        check("R11 write ignored", host_out_rdata, exp);

        finish_run();
    end
endmodule